// File: doc/BRIEF.md
# Speculative Windowed Carry Adder

This block is a purely combinational W-bit adder that accepts small, rare errors in exchange for a short carry path. Sum bit i is formed only from operand positions i down to i−K+1. The carry into that span comes from a guess rather than from the rest of the operands. As a result, the deepest carry logic is a parallel-prefix network of about log2(K) levels instead of log2(W). The operands are treated as plain W-bit vectors, so two's-complement and fixed-point values (for example 4 integer and 60 fraction bits at the default width) add the same way.

The design-time parameter `BIAS_MODE` selects the guess. With 0, the guess is a constant 0, which on average underestimates the sum. With 1, the guess is operand A at the position just below the span. Because that bit is as likely to be 1 as 0, the error distribution becomes unbiased. A `miss` output flags operand pairs whose propagate run is long enough for a guess to matter. When `miss` is low the sum is exact. Setting K equal to W turns the block into an exact adder.

The parameters must satisfy 2 ≤ K ≤ W and BIAS_MODE ∈ {0, 1}. Elaboration stops otherwise.

Top module: `ws_adder`

## Requirements
- R1: Sum bit i depends only on op_a and op_b at positions max(0, i−K+1) through i, plus, when BIAS_MODE is 1 and i ≥ K, op_a[i−K]; it equals bit i of adding that span of both operands with that carry-in.
- R2: With BIAS_MODE = 0, the carry-in of every span is 0.
- R3: Sum bits K−1 down to 0 always equal the low K bits of op_a + op_b.
- R4: With BIAS_MODE = 1, the carry-in of the span for bit i ≥ K is op_a[i−K].
- R5: miss is 1 exactly when some i in K..W−1 has op_a[j] XOR op_b[j] = 1 for every j from i−K+1 to i−1.
- R6: Whenever miss is 0, sum equals (op_a + op_b) mod 2^W.
- R7: With BIAS_MODE = 0, op_a all ones and op_b = 1, sum has bits W−1..K set and bits K−1..0 clear, so the error lands on the MSB.
- R8: With K = W, sum equals (op_a + op_b) mod 2^W for every input and miss stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand; also the source of the anti-bias guess |
| op_b | input | W | Second operand |
| sum | output | W | Approximate sum |
| miss | output | 1 | High when a propagate run may have defeated a span |

## Verification
The bench goes after the cases where the guessed carry decides the result.

- **All-ones operand plus one.** The constant-0 mode must return a sum whose upper bits are all ones, while the anti-bias mode recovers the exact zero. A design that picked the guess from the wrong position, or from op_b, would disagree with the span model on these inputs.
- **Propagate runs at the threshold.** Runs exactly one position shorter than the K−1 threshold, and runs exactly at it, check where `miss` turns on. An off-by-one in the span length would either flag clean sums or let a wrong sum pass unflagged.
- **Random operands.** Fully complementary, random and nearly complementary operands compare every bit against a model that adds each span explicitly. This exposes any carry tree that stitches its segments in the wrong order.
- **Full-width configuration.** A K = W instance must agree with the true sum everywhere.

// File: rtl/ws_pkg.sv
`timescale 1ns/1ps
package ws_pkg;

   // generate / propagate pair of one bit or of a contiguous group
   typedef struct packed {
      logic g;
      logic p;
   } gp_t;

   // merge a higher group with the group directly beneath it
   function automatic gp_t gp_join(input gp_t hi, input gp_t lo);
      gp_t r;
      r.g = hi.g | (hi.p & lo.g);
      r.p = hi.p & lo.p;
      return r;
   endfunction

   localparam gp_t GP_EMPTY = '{g: 1'b0, p: 1'b1};  // neutral element
   localparam gp_t GP_PAD   = '{g: 1'b0, p: 1'b0};  // position below bit 0

endpackage

// File: rtl/ws_bit_gp.sv
`timescale 1ns/1ps
module ws_bit_gp
   import ws_pkg::*;
#(
   parameter int W = 64
) (
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   output gp_t  [W-1:0] gp
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign gp[i].g = op_a[i] & op_b[i];
      assign gp[i].p = op_a[i] ^ op_b[i];
   end

endmodule

// File: rtl/ws_span_tree.sv
`timescale 1ns/1ps
// Node [l][j] holds the group of 2**l positions ending at j; positions
// below bit 0 act as non-propagating zeros, so short groups stay exact.
module ws_span_tree
   import ws_pkg::*;
#(
   parameter int W  = 64,
   parameter int LV = 4
) (
   input  gp_t [W-1:0]         base,
   output gp_t [LV-1:0][W-1:0] lvl
);

   assign lvl[0] = base;

   for (genvar l = 1; l < LV; l++) begin : g_lvl
      localparam int HOP = 1 << (l - 1);
      for (genvar j = 0; j < W; j++) begin : g_node
         if (j >= HOP) begin : g_pair
            assign lvl[l][j] = gp_join(lvl[l-1][j], lvl[l-1][j-HOP]);
         end else begin : g_edge
            assign lvl[l][j] = gp_join(lvl[l-1][j], GP_PAD);
         end
      end
   end

endmodule

// File: rtl/ws_window_carry.sv
`timescale 1ns/1ps
// For each bit i, stitches the K-1 positions below it out of power-of-two
// groups, then folds in the guessed carry at the bottom of that span.
module ws_window_carry
   import ws_pkg::*;
#(
   parameter int W  = 64,
   parameter int K  = 16,
   parameter int LV = 4
) (
   input  gp_t [LV-1:0][W-1:0] lvl,
   input  logic [W-1:0]        guess,
   output logic [W-1:0]        carry,
   output logic                miss
);

   localparam int SPAN = K - 1;
   logic [W-1:0] run_hit;

   assign carry[0]   = 1'b0;
   assign run_hit[0] = 1'b0;

   for (genvar i = 1; i < W; i++) begin : g_col
      gp_t acc;
      always_comb begin
         int top;
         acc = GP_EMPTY;
         top = i - 1;
         for (int b = 0; b < LV; b++) begin
            if (SPAN[b]) begin
               if (top >= 0) acc = gp_join(acc, lvl[b][top]);
               else          acc = gp_join(acc, GP_PAD);
               top = top - (1 << b);
            end
         end
      end
      assign carry[i] = acc.g | (acc.p & guess[i]);
      if (i >= K) begin : g_hi
         assign run_hit[i] = acc.p;
      end else begin : g_lo
         assign run_hit[i] = 1'b0;
      end
   end

   assign miss = |run_hit;

endmodule

// File: rtl/ws_adder.sv
`timescale 1ns/1ps
module ws_adder
   import ws_pkg::*;
#(
   parameter int W         = 64,
   parameter int K         = 16,
   parameter int BIAS_MODE = 0
) (
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   output logic [W-1:0] sum,
   output logic         miss
);

   localparam int LV = (K > 1) ? $clog2(K) : 1;

   if (W < 2) begin : g_bad_w
      $error("ws_adder: W must be at least 2");
   end
   if (K < 2 || K > W) begin : g_bad_k
      $error("ws_adder: K must lie in 2..W");
   end
   if (BIAS_MODE != 0 && BIAS_MODE != 1) begin : g_bad_mode
      $error("ws_adder: BIAS_MODE must be 0 or 1");
   end

   gp_t  [W-1:0]         gp;
   gp_t  [LV-1:0][W-1:0] lvl;
   logic [W-1:0]         guess;
   logic [W-1:0]         carry;
   logic [W-1:0]         prop;

   ws_bit_gp #(.W(W)) u_gp (
      .op_a (op_a),
      .op_b (op_b),
      .gp   (gp)
   );

   ws_span_tree #(.W(W), .LV(LV)) u_tree (
      .base (gp),
      .lvl  (lvl)
   );

   for (genvar i = 0; i < W; i++) begin : g_guess
      if (BIAS_MODE == 1 && i >= K) begin : g_anti
         assign guess[i] = op_a[i-K];
      end else begin : g_zero
         assign guess[i] = 1'b0;
      end
      assign prop[i] = gp[i].p;
   end

   ws_window_carry #(.W(W), .K(K), .LV(LV)) u_win (
      .lvl   (lvl),
      .guess (guess),
      .carry (carry),
      .miss  (miss)
   );

   assign sum = prop ^ carry;

endmodule

// File: rtl/ws_adder_chk.sv
`timescale 1ns/1ps
module ws_adder_chk #(
   parameter int W         = 64,
   parameter int K         = 16,
   parameter int BIAS_MODE = 0
) (
   input logic [W-1:0] op_a,
   input logic [W-1:0] op_b,
   input logic [W-1:0] sum,
   input logic         miss
);

   logic [W-1:0] exact;
   logic [K-1:0] low_exact;
   assign exact     = op_a + op_b;
   assign low_exact = op_a[K-1:0] + op_b[K-1:0];

   always_comb begin
      if (!$isunknown({op_a, op_b, sum, miss})) begin
         assert_low_exact_R3: assert (sum[K-1:0] == low_exact)
            else $error("low bits differ from exact sum");
         assert_clean_exact_R6: assert (miss || sum == exact)
            else $error("unflagged sum differs from exact sum");
      end
   end

   if (K == W) begin : g_full
      always_comb begin
         if (!$isunknown({op_a, op_b, sum, miss})) begin
            assert_full_exact_R8: assert (sum == exact && !miss)
               else $error("full-width instance inexact");
         end
      end
   end else begin : g_part
      always_comb begin
         if (!$isunknown({op_a, op_b, miss})) begin
            assert_full_run_flag_R5: assert (!(&(op_a ^ op_b)) || miss)
               else $error("complete propagate run not flagged");
         end
      end
   end

endmodule

bind ws_adder ws_adder_chk #(.W(W), .K(K), .BIAS_MODE(BIAS_MODE)) u_chk (
   .op_a (op_a),
   .op_b (op_b),
   .sum  (sum),
   .miss (miss)
);

// File: tb/sim_ws_adder.sv
`timescale 1ns/1ps
module sim_ws_adder;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [63:0] ina = '0, inb = '0;
   logic [63:0] s0, s1;
   logic [31:0] s2;
   logic        m0, m1, m2;

   int nchk = 0, nfail = 0, cyc = 0;

   // default: W=64, K=16, constant-0 guess
   ws_adder #(.W(64), .K(16), .BIAS_MODE(0)) u0 (
      .op_a(ina), .op_b(inb), .sum(s0), .miss(m0));
   // anti-bias guess
   ws_adder #(.W(64), .K(16), .BIAS_MODE(1)) u1 (
      .op_a(ina), .op_b(inb), .sum(s1), .miss(m1));
   // full-width window
   ws_adder #(.W(32), .K(32), .BIAS_MODE(0)) u2 (
      .op_a(ina[31:0]), .op_b(inb[31:0]), .sum(s2), .miss(m2));

   // {expected miss for K=16, a, b}
   localparam logic [128:0] VEC [9] = '{
      {1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
      {1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000},
      {1'b1, 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA},
      {1'b1, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF},
      {1'b0, 64'h0000_0000_0000_7FFF, 64'h0000_0000_0000_0001},
      {1'b0, 64'h0000_0000_7FFF_0000, 64'h0000_0000_0001_0000},
      {1'b1, 64'h0000_0000_FFFF_0000, 64'h0000_0000_0000_0000},
      {1'b1, 64'h0000_7FFF_0000_0000, 64'h0000_0000_0000_0000},
      {1'b0, 64'h0000_3FFF_0000_0000, 64'h0000_0000_0000_0000}
   };

   function automatic logic [63:0] model_sum(input logic [63:0] a, b,
                                             input int w, k, mode);
      logic [63:0] r;
      logic c, s;
      int lo;
      r = '0;
      for (int i = 0; i < w; i++) begin
         lo = i - k + 1;
         if (lo <= 0) begin
            lo = 0;
            c  = 1'b0;
         end else begin
            c = (mode == 1) ? a[lo-1] : 1'b0;
         end
         s = 1'b0;
         for (int j = lo; j <= i; j++) begin
            s = a[j] ^ b[j] ^ c;
            c = (a[j] & b[j]) | (c & (a[j] ^ b[j]));
         end
         r[i] = s;
      end
      return r;
   endfunction

   function automatic logic model_miss(input logic [63:0] a, b, input int w, k);
      logic hit, all1;
      hit = 1'b0;
      for (int i = k; i < w; i++) begin
         all1 = 1'b1;
         for (int j = i - k + 1; j <= i - 1; j++) all1 &= a[j] ^ b[j];
         hit |= all1;
      end
      return hit;
   endfunction

   task automatic check(input logic ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [63:0] a, b);
      @(negedge clk);
      ina = a;
      inb = b;
      @(posedge clk);
      #1;
   endtask

   task automatic run_vec(input logic [63:0] a, b);
      logic [63:0] e0, e1, ex;
      logic [31:0] ex32;
      logic        em;
      drive(a, b);
      e0   = model_sum(a, b, 64, 16, 0);
      e1   = model_sum(a, b, 64, 16, 1);
      em   = model_miss(a, b, 64, 16);
      ex   = a + b;
      ex32 = a[31:0] + b[31:0];
      check(s0 == e0, "R1 R2 constant-0 span sum", s0, e0);
      check(s0[15:0] == ex[15:0], "R3 low bits exact", {48'h0, s0[15:0]}, {48'h0, ex[15:0]});
      check(m0 == em, "R5 miss flag (mode 0)", {63'h0, m0}, {63'h0, em});
      if (!em) check(s0 == ex, "R6 clean sum exact", s0, ex);
      check(s1 == e1, "R4 anti-bias span sum", s1, e1);
      check(m1 == em, "R5 miss flag (mode 1)", {63'h0, m1}, {63'h0, em});
      check(s2 == ex32 && !m2, "R8 full-width exact", {31'h0, m2, s2}, {32'h0, ex32});
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      logic [63:0] a, b;
      // reset state: zero operands give zero sum and no miss
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      #1;
      check(s0 == 64'h0 && !m0, "R2 reset-state zero sum", s0, 64'h0);
      check(s1 == 64'h0 && !m1, "R4 reset-state zero sum", s1, 64'h0);

      // table of directed vectors
      for (int v = 0; v < 9; v++) begin
         run_vec(VEC[v][127:64], VEC[v][63:0]);
         check(m0 == VEC[v][128], "R5 table miss", {63'h0, m0}, {63'h0, VEC[v][128]});
      end

      // worst case: all ones plus one
      drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001);
      check(s0 == 64'hFFFF_FFFF_FFFF_0000, "R7 MSB-side error in constant-0 mode",
            s0, 64'hFFFF_FFFF_FFFF_0000);
      check(s1 == 64'h0, "R4 anti-bias recovers exact zero", s1, 64'h0);
      check(m0 && m1, "R5 long run flagged", {62'h0, m0, m1}, 64'h3);

      // random operands
      for (int r = 0; r < 300; r++) begin
         a = {$urandom, $urandom};
         b = {$urandom, $urandom};
         run_vec(a, b);
      end

      // nearly complementary operands: long propagate runs
      for (int r = 0; r < 300; r++) begin
         a = {$urandom, $urandom};
         b = ~a;
         b[$urandom % 64] ^= 1'b1;
         if (r % 3 == 0) b[$urandom % 64] ^= 1'b1;
         run_vec(a, b);
      end

      // complementary operands
      for (int r = 0; r < 50; r++) begin
         a = {$urandom, $urandom};
         run_vec(a, ~a);
         check(m0, "R5 complementary flagged", {63'h0, m0}, 64'h1);
      end

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule